// File: doc/BRIEF.md
# Strobed Burst Write Slave with Lane-Window Checking

This block is the write side of a memory-mapped slave on a 128-bit data bus. It accepts one address command at a time, then takes the write beats of that burst. Each beat's data goes into a small internal memory of 16 words of 16 bytes, and the block returns one write response when the burst is complete.

Two burst kinds are handled. In a constant-address burst every beat lands on the same word and the same lane window, but each beat carries its own strobe. Successive beats therefore merge different bytes into one location. In an incrementing burst the address advances by the transfer size on every beat, and the lane window moves with it. For every beat the block works out which byte lanes the address and size allow. Strobe bits outside that window are dropped and latch a sticky error flag. A `w_last` flag that disagrees with the beat count latches a second sticky flag. A combinational read port lets a checker inspect any memory word.

Top module: `fixed_burst_wr`

## Requirements
- R1: After reset, `aw_ready` is 1, `w_ready` and `b_valid` are 0, both error flags are 0 and every memory word reads as zero.
- R2: A command is accepted only while no burst is open. `w_ready` is 1 from the cycle after acceptance until the final beat. `aw_valid` is ignored during the data and response phases.
- R3: A burst has `aw_len`+1 beats and ends on that count. `b_valid` rises the cycle after the final beat and carries `b_resp`=00 until `b_ready` is seen. When `w_last` is 1 on a beat other than the final one, or 0 on the final beat, `err_last` latches to 1.
- R4: The lane window of a beat spans 2^S lanes, where S is `aw_size` capped at 4. Its lowest lane is the address modulo 16, rounded down to a multiple of 2^S.
- R5: With `aw_burst`=00 (constant), every beat targets the word and window of the first beat. Each beat writes exactly the window bytes whose strobe bits are set on that beat.
- R6: With `aw_burst`=01 (incrementing), the address of each later beat is the previous address rounded down to 2^S, plus 2^S. The window follows it, including into the next memory word.
- R7: A beat whose strobe is all zeros is accepted and changes no memory byte.
- R8: Strobe bits set outside the window do not write their bytes and latch `err_strb` to 1 until reset. The response is still 00.
- R9: `dbg_data` shows memory word `dbg_idx` in the same cycle. Byte k of the word sits at bits [8k+7:8k], and word index is address bits [7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Command valid |
| aw_ready | output | 1 | Command accepted when high |
| aw_addr | input | 8 | Byte address of the first beat |
| aw_len | input | 8 | Beats minus one |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_burst | input | 2 | 00 constant address, 01 incrementing |
| w_valid | input | 1 | Beat valid |
| w_ready | output | 1 | Beat accepted when high |
| w_data | input | 128 | Beat data |
| w_strb | input | 16 | Per-byte write strobes |
| w_last | input | 1 | Sender's final-beat marker |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response taken |
| b_resp | output | 2 | Response code, always 00 |
| err_strb | output | 1 | Sticky: strobe outside window seen |
| err_last | output | 1 | Sticky: final-beat marker mismatch |
| dbg_idx | input | 4 | Word index to inspect |
| dbg_data | output | 128 | Inspected memory word |

## Verification
Bytes accepted on a beat edge become visible on `dbg_data` one cycle later. `w_ready` rises one cycle after the command edge, and `b_valid` one cycle after the final beat edge. The error flags update on the same edge as the beat that causes them. The bench changes inputs on the falling edge and samples each result on the falling edge right after the rising edge that produces it. It keeps a byte model of the memory and compares all 16 words after every burst, and it checks the flags and handshakes at each of those points.

// File: rtl/fixed_burst_wr.sv
module fixed_burst_wr #(
  parameter int DATA_BYTES = 16,
  parameter int DEPTH      = 16,
  parameter int LEN_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    aw_valid,
  output logic                    aw_ready,
  input  logic [7:0]              aw_addr,
  input  logic [LEN_W-1:0]        aw_len,
  input  logic [2:0]              aw_size,
  input  logic [1:0]              aw_burst,
  input  logic                    w_valid,
  output logic                    w_ready,
  input  logic [8*DATA_BYTES-1:0] w_data,
  input  logic [DATA_BYTES-1:0]   w_strb,
  input  logic                    w_last,
  output logic                    b_valid,
  input  logic                    b_ready,
  output logic [1:0]              b_resp,
  output logic                    err_strb,
  output logic                    err_last,
  input  logic [3:0]              dbg_idx,
  output logic [8*DATA_BYTES-1:0] dbg_data
);
  localparam int LANE_W = $clog2(DATA_BYTES);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ADDR_W = LANE_W + IDX_W;
  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int SPAN_W = 2 * DATA_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_RESP} state_t;

  state_t            state;
  logic [ADDR_W-1:0] cur_addr;
  logic [2:0]        cur_size;
  logic              cur_fixed;
  logic [LEN_W-1:0]  beats_left;
  logic [DATA_W-1:0] mem [DEPTH];

  logic              beat, is_last, stray;
  logic [ADDR_W:0]   lanes;
  logic [ADDR_W-1:0] base, next_addr;
  logic [SPAN_W-1:0] span;
  logic [DATA_BYTES-1:0] win, keep;
  logic [IDX_W-1:0]  idx;

  assign aw_ready  = (state == S_IDLE);
  assign w_ready   = (state == S_DATA);
  assign b_valid   = (state == S_RESP);
  assign b_resp    = 2'b00;
  assign beat      = w_valid && w_ready;
  assign is_last   = (beats_left == '0);
  assign lanes     = (ADDR_W+1)'(1) << cur_size;
  assign base      = cur_addr & ~ADDR_W'(lanes - (ADDR_W+1)'(1));
  assign next_addr = base + ADDR_W'(lanes);
  assign span      = (SPAN_W'(1) << lanes) - SPAN_W'(1);
  assign win       = DATA_BYTES'(span << base[LANE_W-1:0]);
  assign keep      = w_strb & win;
  assign stray     = |(w_strb & ~win);
  assign idx       = cur_addr[ADDR_W-1:LANE_W];
  assign dbg_data  = mem[dbg_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_addr   <= '0;
      cur_size   <= '0;
      cur_fixed  <= 1'b0;
      beats_left <= '0;
      err_strb   <= 1'b0;
      err_last   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (aw_valid) begin
          state      <= S_DATA;
          cur_addr   <= ADDR_W'(aw_addr);
          cur_size   <= (aw_size > 3'(LANE_W)) ? 3'(LANE_W) : aw_size;
          cur_fixed  <= (aw_burst == 2'b00);
          beats_left <= aw_len;
        end
        S_DATA: if (beat) begin
          if (stray) err_strb <= 1'b1;
          if (w_last != is_last) err_last <= 1'b1;
          if (!cur_fixed) cur_addr <= next_addr;
          if (is_last) state <= S_RESP;
          else beats_left <= beats_left - 1'b1;
        end
        S_RESP: if (b_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (beat) begin
      for (int b = 0; b < DATA_BYTES; b++)
        if (keep[b]) mem[idx][8*b +: 8] <= w_data[8*b +: 8];
    end
  end

  a_r2_aw_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready) |=> (w_ready && !aw_ready));
  a_r3_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && b_resp == 2'b00));
  a_r3_last_to_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && is_last) |=> (b_valid && !w_ready));
  a_r5_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && cur_fixed && !is_last) |=> (cur_addr == $past(cur_addr)));
  a_r8_stray_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && stray) |=> err_strb);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_strb |=> err_strb);
endmodule

// File: tb/sim_fixed_burst_wr.sv
module sim_fixed_burst_wr;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         aw_valid = 0, w_valid = 0, w_last = 0, b_ready = 0;
  logic [7:0]   aw_addr = 0, aw_len = 0;
  logic [2:0]   aw_size = 0;
  logic [1:0]   aw_burst = 0;
  logic [127:0] w_data = 0;
  logic [15:0]  w_strb = 0;
  logic [3:0]   dbg_idx = 0;
  logic         aw_ready, w_ready, b_valid, err_strb, err_last;
  logic [1:0]   b_resp;
  logic [127:0] dbg_data;

  int nchk = 0, nerr = 0;
  logic [7:0]   exp_mem [16][16];
  logic         exp_es = 0, exp_el = 0;
  logic [15:0]  bs [8];
  logic [127:0] bd [8];

  fixed_burst_wr u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 16; k++) bd[i][8*k +: 8] = seed + 8'(16*i + k);
  endtask

  task automatic check_mem(input string tag);
    logic [127:0] e;
    for (int w = 0; w < 16; w++) begin
      dbg_idx = 4'(w);
      #1;
      for (int k = 0; k < 16; k++) e[8*k +: 8] = exp_mem[w][k];
      chk(dbg_data == e, tag, dbg_data, e);
    end
  endtask

  task automatic run_burst(input string tag, input logic [7:0] addr, input logic [7:0] len,
                           input logic [2:0] size, input logic [1:0] btype, input int last_at);
    int a, lanes, lo;
    a = addr;
    lanes = 1 << ((size > 4) ? 4 : size);
    @(negedge clk);
    aw_valid = 1; aw_addr = addr; aw_len = len; aw_size = size; aw_burst = btype;
    @(negedge clk);
    aw_addr = 8'hFF; aw_burst = 2'b01;
    chk(w_ready == 1 && aw_ready == 0, {"R2 data phase opens ", tag}, {w_ready, aw_ready}, 2'b10);
    for (int i = 0; i <= int'(len); i++) begin
      w_valid = 1; w_data = bd[i]; w_strb = bs[i]; w_last = (i == last_at);
      lo = (a % 16) & ~(lanes - 1);
      for (int k = 0; k < 16; k++) begin
        if (bs[i][k] && k >= lo && k < lo + lanes) exp_mem[(a / 16) % 16][k] = bd[i][8*k +: 8];
        else if (bs[i][k]) exp_es = 1;
      end
      if ((i == last_at) != (i == int'(len))) exp_el = 1;
      if (btype != 2'b00) a = ((a & ~(lanes - 1)) + lanes) % 256;
      @(negedge clk);
      if (i < int'(len))
        chk(b_valid == 0 && w_ready == 1 && aw_ready == 0, {"R3 burst still open ", tag},
            {b_valid, w_ready, aw_ready}, 3'b010);
    end
    w_valid = 0; w_last = 0;
    chk(b_valid == 1 && w_ready == 0 && b_resp == 2'b00, {"R3 response after final beat ", tag},
        {b_valid, w_ready, b_resp}, 4'b1000);
    @(negedge clk);
    chk(b_valid == 1 && b_resp == 2'b00, {"R3 response held ", tag}, {b_valid, b_resp}, 3'b100);
    aw_valid = 0;
    b_ready = 1;
    @(negedge clk);
    b_ready = 0;
    chk(b_valid == 0 && aw_ready == 1, {"R2 back to idle ", tag}, {b_valid, aw_ready}, 2'b01);
    chk(err_strb == exp_es, {"R8 err_strb ", tag}, err_strb, exp_es);
    chk(err_last == exp_el, {"R3 err_last ", tag}, err_last, exp_el);
    check_mem({"R9 memory ", tag});
  endtask

  task automatic t_reset;
    for (int w = 0; w < 16; w++) for (int k = 0; k < 16; k++) exp_mem[w][k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(aw_ready == 1 && w_ready == 0 && b_valid == 0, "R1 handshake reset",
        {aw_ready, w_ready, b_valid}, 3'b100);
    chk(err_strb == 0 && err_last == 0, "R1 flags reset", {err_strb, err_last}, 2'b00);
    check_mem("R1 memory reset");
  endtask

  task automatic t_fixed_merge;
    fill(8'h10);
    bs[0] = 16'h000F; bs[1] = 16'h000A; bs[2] = 16'h0006; bs[3] = 16'h0001;
    run_burst("R5 R4 constant burst four beats", 8'h00, 8'd3, 3'd2, 2'b00, 3);
  endtask

  task automatic t_single;
    fill(8'h60);
    bs[0] = 16'h0020;
    run_burst("R6 single beat", 8'h25, 8'd0, 3'd0, 2'b01, 0);
  endtask

  task automatic t_incr_cross;
    fill(8'h80);
    for (int i = 0; i < 4; i++) bs[i] = 16'hFFFF & ~16'h0000;
    bs[0] = 16'h0F00; bs[1] = 16'hF000; bs[2] = 16'h000F; bs[3] = 16'h00F0;
    run_burst("R6 incrementing across words", 8'h38, 8'd3, 3'd2, 2'b01, 3);
  endtask

  task automatic t_unaligned_fixed;
    fill(8'hA0);
    bs[0] = 16'hFF00; bs[1] = 16'h3C00;
    run_burst("R4 unaligned constant 8-byte window", 8'h6B, 8'd1, 3'd3, 2'b00, 1);
  endtask

  task automatic t_zero;
    fill(8'hC0);
    bs[0] = 16'h0000; bs[1] = 16'h0000;
    run_burst("R7 all-zero strobes", 8'h00, 8'd1, 3'd2, 2'b00, 1);
  endtask

  task automatic t_stray;
    fill(8'hD0);
    bs[0] = 16'h00FF; bs[1] = 16'h0010;
    run_burst("R8 strobes outside window", 8'h54, 8'd1, 3'd1, 2'b00, 1);
  endtask

  task automatic t_bad_last;
    fill(8'hE0);
    bs[0] = 16'hFFFF; bs[1] = 16'h00FF;
    run_burst("R3 early last marker", 8'h90, 8'd1, 3'd4, 2'b00, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed_merge();
    t_single();
    t_incr_cross();
    t_unaligned_fixed();
    t_zero();
    t_stray();
    t_bad_last();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule